// File: doc/BRIEF.md
# Byte-to-Wide-Word Access Bridge

This block lets a requester that works on single bytes use a memory that only transfers whole aligned words. The requester offers one byte address at a time, together with a write flag and, for writes, one data byte. The bridge turns every request into word-sized operations on the memory port. For a read, it fetches the aligned word and returns only the addressed byte. For a write, it fetches the aligned word, replaces one byte in a local copy and stores the whole word back. This read-modify-write is needed because the memory port has no per-byte write enable.

The memory word width is a parameter and may be 32, 64 or 128 bits. The memory side uses a request/grant pair for commands. Read data comes back later on a separate valid strobe, after a latency that is not fixed. Only one request is handled at a time. The requester sees ready drop while the bridge is busy and gets a one-cycle response strobe when the request is finished.

Top module: `byte_word_bridge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_ready is 1, and mem_req and rsp_valid are 0.
- R2: Every memory command carries a byte address whose low log2(WORD_BITS/8) bits are zero: the address rounded down to the enclosing word (with 16-byte words, byte 18 maps to 16).
- R3: A read returns byte lane (address mod WORD_BITS/8) of the fetched word, where lane k occupies bits 8k+7..8k, so lane 0 is the least significant byte.
- R4: A write issues one word read and then one word write to the same aligned address. In the written word only the addressed lane carries the new byte, and every other lane keeps the value that was read.
- R5: req_ready goes low on the cycle after a request is accepted and stays low until the response strobe. It is also low in the cycle of the response strobe.
- R6: Read data is taken only on a mem_rvalid pulse, and any read latency of one cycle or more gives the correct result.
- R7: A write is reported only after the write-back command has been granted. rsp_valid is high for exactly one cycle per request, and rsp_rdata is 0 in a write response.
- R8: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_wdata unchanged until the cycle in which mem_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester offers a byte access |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | ADDR_BITS | Byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 8 | Byte to be written |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte that was read (0 for a write) |
| mem_req | output | 1 | Word command pending |
| mem_gnt | input | 1 | Memory accepts the pending command |
| mem_we | output | 1 | Command is a word write |
| mem_addr | output | ADDR_BITS | Aligned byte address of the word |
| mem_wdata | output | WORD_BITS | Word to be written |
| mem_rvalid | input | 1 | Read word is present on mem_rdata |
| mem_rdata | input | WORD_BITS | Read word |

## Verification
The assertions check on every cycle that commands are word-aligned and that a pending command is held steady until it is granted. They also check that ready drops after acceptance, that the response strobe lasts one cycle, and that ready is low while a response is delivered. The directed scenarios show what a per-cycle property cannot: the correct lane is returned for each address, and a patched word leaves its neighbouring bytes untouched. The bench drives back-to-back writes to adjacent lanes of one word, reads again after long read delays, and compares the final memory contents with its own model.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_WRITE_BACK,
    ST_RESPOND
  } bwb_state_e;
endpackage

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
  import bwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic is_write,
  input  logic mem_gnt,
  input  logic mem_rvalid,
  output logic req_ready,
  output logic accept,
  output logic word_load,
  output logic mem_req,
  output logic mem_we,
  output logic rsp_valid
);

  bwb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (req_valid) state_d = ST_READ_REQ;
      ST_READ_REQ:   if (mem_gnt) state_d = ST_READ_WAIT;
      ST_READ_WAIT:  if (mem_rvalid) state_d = is_write ? ST_WRITE_BACK : ST_RESPOND;
      ST_WRITE_BACK: if (mem_gnt) state_d = ST_RESPOND;
      ST_RESPOND:    state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign word_load = (state_q == ST_READ_WAIT) && mem_rvalid;
  assign mem_req   = (state_q == ST_READ_REQ) || (state_q == ST_WRITE_BACK);
  assign mem_we    = (state_q == ST_WRITE_BACK);
  assign rsp_valid = (state_q == ST_RESPOND);

endmodule

// File: rtl/bwb_datapath.sv
module bwb_datapath #(
  parameter int WORD_BITS = 64,
  parameter int ADDR_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 word_load,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic                 req_write,
  input  logic [7:0]           req_wdata,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 is_write,
  output logic [ADDR_BITS-1:0] word_addr,
  output logic [WORD_BITS-1:0] patched,
  output logic [7:0]           lane_byte
);

  localparam int BYTES = WORD_BITS / 8;
  localparam int LB    = $clog2(BYTES);

  logic [ADDR_BITS-1:0] addr_q;
  logic [7:0]           byte_q;
  logic                 wr_q;
  logic [WORD_BITS-1:0] word_q;
  logic [LB-1:0]        lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      byte_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      byte_q <= req_wdata;
      wr_q   <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (word_load) word_q <= mem_rdata;
  end

  assign lane      = addr_q[LB-1:0];
  assign is_write  = wr_q;
  assign word_addr = {addr_q[ADDR_BITS-1:LB], {LB{1'b0}}};
  assign lane_byte = word_q[{lane, 3'b000} +: 8];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign patched[8*g +: 8] = (lane == LB'(g)) ? byte_q : word_q[8*g +: 8];
  end

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge #(
  parameter int WORD_BITS = 64,
  parameter int ADDR_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_BITS-1:0] req_addr,
  input  logic                 req_write,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_rdata,
  output logic                 mem_req,
  input  logic                 mem_gnt,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [WORD_BITS-1:0] mem_rdata
);

  logic accept, word_load, is_write;
  logic [7:0] lane_byte;

  bwb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .is_write   (is_write),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .req_ready  (req_ready),
    .accept     (accept),
    .word_load  (word_load),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .rsp_valid  (rsp_valid)
  );

  bwb_datapath #(.WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .word_load (word_load),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .mem_rdata (mem_rdata),
    .is_write  (is_write),
    .word_addr (mem_addr),
    .patched   (mem_wdata),
    .lane_byte (lane_byte)
  );

  assign rsp_rdata = (rsp_valid && !is_write) ? lane_byte : 8'h00;

endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int WORD_BITS = 64,
  parameter int ADDR_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 mem_req,
  input logic                 mem_gnt,
  input logic                 mem_we,
  input logic [ADDR_BITS-1:0] mem_addr,
  input logic [WORD_BITS-1:0] mem_wdata
);

  localparam int LB = $clog2(WORD_BITS / 8);

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LB-1:0] == '0));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  busy_at_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R7
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  wb_then_respond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt) |=> rsp_valid);

endmodule

bind byte_word_bridge bwb_checker #(.WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS)) u_bwb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/byte_word_bridge_bench.sv
module byte_word_bridge_bench;
  localparam int WB    = 128;
  localparam int AB    = 12;
  localparam int NWORD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AB-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [7:0] rsp_rdata;
  logic [AB-1:0] mem_addr;
  logic [WB-1:0] mem_wdata;
  logic mem_gnt, mem_rvalid;
  logic [WB-1:0] mem_rdata;

  int n_checks = 0;
  int n_fails = 0;
  int long_lat = 0;

  always #2.5 clk = ~clk;

  byte_word_bridge #(.WORD_BITS(WB), .ADDR_BITS(AB)) u_byte_word_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Behavioural word memory with random grant and read delays
  logic [WB-1:0] mem_arr [NWORD];
  logic [WB-1:0] golden  [NWORD];
  logic          rd_pend, misaligned;
  logic [WB-1:0] rd_data;
  int            rd_cnt, gnt_wait, n_rd_cmd, n_wr_cmd;

  function automatic logic [WB-1:0] init_word(int w);
    logic [WB-1:0] v;
    for (int b = 0; b < WB/8; b++) v[8*b +: 8] = 8'(w*16 + b) ^ 8'hA5;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) mem_arr[i] <= init_word(i);
      mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      rd_pend <= 1'b0; rd_data <= '0; rd_cnt <= 0; gnt_wait <= 0;
      misaligned <= 1'b0; n_rd_cmd <= 0; n_wr_cmd <= 0;
    end else begin
      mem_gnt <= 1'b0;
      mem_rvalid <= 1'b0;
      if (rd_pend) begin
        if (rd_cnt <= 1) begin
          mem_rvalid <= 1'b1; mem_rdata <= rd_data; rd_pend <= 1'b0;
        end else rd_cnt <= rd_cnt - 1;
      end else if (mem_req && !mem_gnt) begin
        if (mem_addr[3:0] != 4'h0) misaligned <= 1'b1;
        if (gnt_wait > 0) gnt_wait <= gnt_wait - 1;
        else begin
          mem_gnt <= 1'b1;
          gnt_wait <= int'($urandom_range(0, 2));
          if (mem_we) begin
            mem_arr[mem_addr[7:4]] <= mem_wdata;
            n_wr_cmd <= n_wr_cmd + 1;
          end else begin
            rd_pend <= 1'b1;
            rd_data <= mem_arr[mem_addr[7:4]];
            rd_cnt  <= int'($urandom_range(1, 3)) + long_lat;
            n_rd_cmd <= n_rd_cmd + 1;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AB-1:0] a, input logic wr, input logic [7:0] d,
                        output logic [7:0] rd, output bit busy_ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 1'b0;
    rd = rsp_rdata;
    if (wr) golden[a[7:4]][8*a[3:0] +: 8] = d;
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 ready after reset", WB'(req_ready), 1);
    check(mem_req === 1'b0, "R1 no mem cmd after reset", WB'(mem_req), 0);
    check(rsp_valid === 1'b0, "R1 no response after reset", WB'(rsp_valid), 0);
  endtask

  task automatic t_read_lanes;
    logic [7:0] rd; bit b;
    for (int l = 0; l < 16; l += 5) begin
      access(AB'(16 + l), 1'b0, 8'h00, rd, b);
      check(rd == golden[1][8*l +: 8], "R3 lane select", WB'(rd), WB'(golden[1][8*l +: 8]));
      check(b, "R5 ready low while busy", WB'(b), 1);
    end
    access(AB'(18), 1'b0, 8'h00, rd, b);
    check(rd == (8'd18 ^ 8'hA5), "R3 byte 18 is lane 2 of word 16", WB'(rd), WB'(8'd18 ^ 8'hA5));
  endtask

  task automatic t_write_19;
    logic [7:0] rd; bit b; int r0, w0;
    r0 = n_rd_cmd; w0 = n_wr_cmd;
    access(AB'(19), 1'b1, 8'h3C, rd, b);
    check(rd == 8'h00, "R7 write response carries no data", WB'(rd), 0);
    check(b, "R5 ready low during write", WB'(b), 1);
    check(n_rd_cmd - r0 == 1 && n_wr_cmd - w0 == 1, "R4 one word read and one word write",
          WB'((n_rd_cmd - r0) * 16 + (n_wr_cmd - w0)), WB'(17));
    check(mem_arr[1] == golden[1], "R4 only lane 3 of word 16 changed", mem_arr[1], golden[1]);
  endtask

  task automatic t_neighbours;
    logic [7:0] rd; bit b;
    access(AB'(32 + 4), 1'b1, 8'h11, rd, b);
    access(AB'(32 + 5), 1'b1, 8'h22, rd, b);
    access(AB'(32 + 6), 1'b1, 8'h33, rd, b);
    access(AB'(32 + 15), 1'b1, 8'h44, rd, b);
    access(AB'(32), 1'b1, 8'h55, rd, b);
    check(mem_arr[2] == golden[2], "R4 adjacent lane writes keep each other", mem_arr[2], golden[2]);
    access(AB'(32 + 5), 1'b0, 8'h00, rd, b);
    check(rd == 8'h22, "R3 read back of patched lane", WB'(rd), WB'(8'h22));
  endtask

  task automatic t_long_latency;
    logic [7:0] rd; bit b;
    long_lat = 12;
    access(AB'(48 + 9), 1'b0, 8'h00, rd, b);
    check(rd == golden[3][8*9 +: 8], "R6 read with long latency", WB'(rd), WB'(golden[3][8*9 +: 8]));
    access(AB'(48 + 9), 1'b1, 8'h9E, rd, b);
    check(mem_arr[3] == golden[3], "R6 write with long read latency", mem_arr[3], golden[3]);
    long_lat = 0;
  endtask

  task automatic t_final;
    check(misaligned === 1'b0, "R2 all commands word aligned", WB'(misaligned), 0);
    for (int i = 0; i < NWORD; i++)
      check(mem_arr[i] == golden[i], "R4 final memory image", mem_arr[i], golden[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWORD; i++) golden[i] = init_word(i);
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && mem_req === 1'b0, "R1 state during reset", WB'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_lanes();
    t_write_19();
    t_neighbours();
    t_long_latency();
    t_final();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule